// File: doc/BRIEF.md
# AES-128 Round-Key Bank

This block takes one 128-bit cipher key and expands it into the eleven round keys that the AES-128 cipher uses. All of them are written into a local key bank before any data round starts. The expansion engine makes one new round key per clock. It derives each key from the one before it through a byte rotation, four S-box substitutions and a per-round constant.

Once the bank is complete, the block raises a ready flag. A combinational read port then returns any round key by its index, in any order, so the encryption path can walk forward from key 0 and the decryption path can walk backward from key 10. A new load pulse at any time discards the expansion in progress and starts again from the new key.

Top module: `keysched_bank`

## Requirements
- R1: After reset `ready` is 0 and every read index returns an all-zero key until the first load.
- R2: A load sampled at clock edge t drives `ready` to 0 after that edge. `ready` returns to 1 after edge t+10, which is exactly ten edges later.
- R3: Round key 0 read from the bank equals the key presented with the load.
- R4: For each round r from 1 to 10, split the previous key into words w0..w3, with w0 in bits [127:96]. Let t = Sub(w3 rotated left by 8 bits) XOR (rc_r << 24). Then w0' = w0^t, w1' = w1^w0', w2' = w2^w1' and w3' = w3^w2'. Round key r is {w0',w1',w2',w3'}.
- R5: The round constant rc_1 is 8'h01. Each later constant is the previous one doubled in GF(2^8) and reduced by 8'h1B, which gives 01 02 04 08 10 20 40 80 1B 36.
- R6: Sub applies, to every byte, the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 mapped to 0. It then applies the affine map o_i = b_i ^ b_(i+4) ^ b_(i+5) ^ b_(i+6) ^ b_(i+7) ^ c_i, with indices mod 8 and c = 8'h63.
- R7: `rd_key` reflects `rd_idx` in the same cycle, for any index order. Indices 11 to 15 always read as zero.
- R8: A load during expansion restarts it. The final bank holds only keys derived from the latest load, and `ready` timing counts from that load.
- R9: While `ready` is 1 and no load arrives, `ready` stays 1 and the key at a given index does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | One-cycle pulse that captures `key_in` and starts expansion |
| key_in | input | 128 | Cipher key, sampled with `load` |
| ready | output | 1 | All eleven round keys are present in the bank |
| rd_idx | input | 4 | Round index to read |
| rd_key | output | 128 | Round key at `rd_idx`, zero when out of range |

## Verification
The assertions check the following on every cycle: `ready` falls after each load, `ready` rises exactly ten edges after the latest load, the ready state is held, key 0 matches the captured key, and out-of-range indices read as zero. The arithmetic content of keys 1 to 10 cannot be expressed as a simple property: the S-box inverse, the rotation and the constant sequence can only be shown by the bench. The bench compares every index against an independently computed expansion, including a published test key and the all-zero and all-one keys. Restart in mid-expansion and back-to-back loads are likewise exercised only by bench scenarios.

// File: rtl/ks_pkg.sv
package ks_pkg;
   localparam int unsigned BLK_W  = 128;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned NWORDS = BLK_W / WORD_W;
   localparam logic [7:0]  AFF_C  = 8'h63;
   localparam logic [7:0]  RED_P  = 8'h1b;
   localparam logic [7:0]  RC_1   = 8'h01;

   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [WORD_W-1:0] word_t;
   typedef logic [BLK_W-1:0]  blk_t;

   // double in GF(2^8)
   function automatic byte_t ks_xtime(input byte_t a);
      return {a[6:0], 1'b0} ^ (a[7] ? RED_P : 8'h00);
   endfunction

   function automatic byte_t ks_gmul(input byte_t a, input byte_t b);
      byte_t acc, p;
      acc = '0;
      p   = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ p;
         p = ks_xtime(p);
      end
      return acc;
   endfunction

   // a^254 = a^-1 for a != 0, and 0 for a == 0
   function automatic byte_t ks_ginv(input byte_t a);
      byte_t r, sq;
      r  = 8'h01;
      sq = a;
      for (int i = 1; i < 8; i++) begin
         sq = ks_gmul(sq, sq);
         r  = ks_gmul(r, sq);
      end
      return r;
   endfunction

   function automatic byte_t ks_affine(input byte_t b);
      byte_t o;
      for (int i = 0; i < 8; i++)
         o[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ AFF_C[i];
      return o;
   endfunction
endpackage

// File: rtl/ks_sbox.sv
module ks_sbox
   import ks_pkg::*;
(
   input  logic [7:0] din,
   output logic [7:0] dout
);
   byte_t inv_b;

   always_comb begin
      inv_b = ks_ginv(din);
      dout  = ks_affine(inv_b);
   end
endmodule

// File: rtl/ks_round.sv
module ks_round
   import ks_pkg::*;
(
   input  logic [127:0] prev,
   input  logic [7:0]   rcon,
   output logic [127:0] next
);
   word_t w [NWORDS];
   word_t rot_w, sub_w, tmix;

   always_comb begin
      for (int i = 0; i < NWORDS; i++)
         w[i] = prev[BLK_W-1-i*WORD_W -: WORD_W];
      rot_w = {w[NWORDS-1][WORD_W-BYTE_W-1:0], w[NWORDS-1][WORD_W-1 -: BYTE_W]};
   end

   genvar g;
   generate
      for (g = 0; g < WORD_W/BYTE_W; g++) begin : g_lane
         ks_sbox u_sb (
            .din  (rot_w[g*BYTE_W +: BYTE_W]),
            .dout (sub_w[g*BYTE_W +: BYTE_W])
         );
      end
   endgenerate

   always_comb begin
      word_t acc;
      tmix = sub_w ^ {rcon, {(WORD_W-BYTE_W){1'b0}}};
      acc  = w[0] ^ tmix;
      next = '0;
      next[BLK_W-1 -: WORD_W] = acc;
      for (int i = 1; i < NWORDS; i++) begin
         acc = w[i] ^ acc;
         next[BLK_W-1-i*WORD_W -: WORD_W] = acc;
      end
   end
endmodule

// File: rtl/ks_ctrl.sv
module ks_ctrl
   import ks_pkg::*;
#(
   parameter int unsigned NUM_RK = 11,
   parameter int unsigned IDX_W  = $clog2(NUM_RK)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   output logic             busy,
   output logic             ready,
   output logic [IDX_W-1:0] rnd,
   output logic [7:0]       rcon
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_RK-1);
   localparam logic [IDX_W-1:0] FIRST = IDX_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         ready <= 1'b0;
         rnd   <= '0;
         rcon  <= RC_1;
      end else if (load) begin
         busy  <= 1'b1;
         ready <= 1'b0;
         rnd   <= FIRST;
         rcon  <= RC_1;
      end else if (busy) begin
         rcon <= ks_xtime(rcon);
         if (rnd == LAST) begin
            busy  <= 1'b0;
            ready <= 1'b1;
            rnd   <= '0;
         end else begin
            rnd <= rnd + FIRST;
         end
      end
   end
endmodule

// File: rtl/ks_store.sv
module ks_store
   import ks_pkg::*;
#(
   parameter int unsigned NUM_RK = 11,
   parameter int unsigned IDX_W  = $clog2(NUM_RK),
   parameter bit          RD_REG = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [127:0]     wdata,
   output logic [127:0]     last,
   input  logic [IDX_W-1:0] ridx,
   output logic [127:0]     rdata
);
   blk_t bank [NUM_RK];
   blk_t rd_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_RK; i++) bank[i] <= '0;
         last <= '0;
      end else if (we) begin
         for (int i = 0; i < NUM_RK; i++)
            if (int'(widx) == i) bank[i] <= wdata;
         last <= wdata;
      end
   end

   always_comb begin
      rd_c = '0;
      for (int i = 0; i < NUM_RK; i++)
         if (int'(ridx) == i) rd_c = bank[i];
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_c;
         end
      end else begin : g_rd_comb
         assign rdata = rd_c;
      end
   endgenerate
endmodule

// File: rtl/keysched_bank.sv
module keysched_bank
   import ks_pkg::*;
#(
   parameter int unsigned KEY_W  = 128,
   parameter int unsigned NUM_RK = 11,
   parameter int unsigned IDX_W  = $clog2(NUM_RK),
   parameter bit          RD_REG = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [KEY_W-1:0] key_in,
   output logic             ready,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [KEY_W-1:0] rd_key
);
   generate
      if (KEY_W != BLK_W) begin : g_bad_w
         $error("keysched_bank supports only 128-bit keys");
      end
      if (NUM_RK != 11) begin : g_bad_n
         $error("keysched_bank needs exactly 11 round keys");
      end
      if ((1 << IDX_W) < NUM_RK) begin : g_bad_i
         $error("IDX_W too narrow for NUM_RK");
      end
   endgenerate

   logic             busy;
   logic [IDX_W-1:0] rnd;
   logic [7:0]       rcon;
   blk_t             last_key, next_key, wdata;
   logic             we;
   logic [IDX_W-1:0] widx;

   ks_ctrl #(.NUM_RK(NUM_RK), .IDX_W(IDX_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .load(load),
      .busy(busy), .ready(ready), .rnd(rnd), .rcon(rcon)
   );

   ks_round u_round (.prev(last_key), .rcon(rcon), .next(next_key));

   always_comb begin
      we    = load | busy;
      widx  = load ? '0 : rnd;
      wdata = load ? key_in : next_key;
   end

   ks_store #(.NUM_RK(NUM_RK), .IDX_W(IDX_W), .RD_REG(RD_REG)) u_store (
      .clk(clk), .rst_n(rst_n), .we(we), .widx(widx), .wdata(wdata),
      .last(last_key), .ridx(rd_idx), .rdata(rd_key)
   );
endmodule

// File: rtl/ks_checker.sv
module ks_checker #(
   parameter int unsigned NUM_RK = 11,
   parameter int unsigned IDX_W  = 4,
   parameter bit          RD_REG = 1'b0
)(
   input logic             clk,
   input logic             rst_n,
   input logic             load,
   input logic [127:0]     key_in,
   input logic             ready,
   input logic [IDX_W-1:0] rd_idx,
   input logic [127:0]     rd_key
);
   logic [4:0]   since;
   logic [127:0] kept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since <= '0;
         kept  <= '0;
      end else if (load) begin
         since <= 5'd1;
         kept  <= key_in;
      end else if (since != 5'd0 && since != 5'd31) begin
         since <= since + 5'd1;
      end
   end

   // R2: ready is low right after any load edge
   a_r2_drop: assert property (@(posedge clk) disable iff (!rst_n) load |=> !ready);
   // R2 R8: ready rises exactly ten edges after the latest load
   a_r2_rise_time: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> since == 5'(NUM_RK));
   // R9: ready holds without a load
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !load) |=> ready);

   generate
      if (!RD_REG) begin : g_rd
         // R3: key 0 matches the loaded key
         a_r3_key0: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && rd_idx == '0) |-> rd_key == kept);
         // R7: out-of-range reads are zero
         a_r7_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(rd_idx) >= NUM_RK) |-> rd_key == '0);
         // R9: bank content is stable while ready
         a_r9_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && !load) ##1 (rd_idx == $past(rd_idx)) |-> rd_key == $past(rd_key));
      end
   endgenerate
endmodule

bind keysched_bank ks_checker #(.NUM_RK(NUM_RK), .IDX_W(IDX_W), .RD_REG(RD_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .load(load), .key_in(key_in),
   .ready(ready), .rd_idx(rd_idx), .rd_key(rd_key)
);

// File: tb/sim_keysched_bank.sv
`timescale 1ns/1ps
module sim_keysched_bank;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load = 1'b0;
   logic [127:0] key_in = '0;
   logic         ready;
   logic [3:0]   rd_idx = '0;
   logic [127:0] rd_key;

   int n_chk = 0;
   int n_err = 0;
   int since = -1;
   bit done = 1'b0;
   logic [127:0] exp_k [11];

   always #4 clk = ~clk;

   keysched_bank u0 (.clk(clk), .rst_n(rst_n), .load(load), .key_in(key_in),
                     .ready(ready), .rd_idx(rd_idx), .rd_key(rd_key));

   function automatic int bmul(int a, int b);
      int r = 0;
      int x = a;
      for (int i = 0; i < 8; i++) begin
         if ((b >> i) & 1) r = r ^ x;
         x = x << 1;
         if (x & 256) x = x ^ 283;
      end
      return r & 255;
   endfunction

   function automatic int bsub(int x);
      int inv = 0;
      int o = 0;
      for (int y = 1; y < 256; y++) if (bmul(x, y) == 1) inv = y;
      for (int k = 0; k < 5; k++) o = o ^ (((inv << k) | (inv >> (8 - k))) & 255);
      return o ^ 99;
   endfunction

   task automatic expand(input logic [127:0] k);
      int rc = 1;
      logic [31:0] w [44];
      for (int i = 0; i < 4; i++) w[i] = k[127 - 32*i -: 32];
      for (int i = 4; i < 44; i++) begin
         logic [31:0] t = w[i-1];
         if (i % 4 == 0) begin
            t = {t[23:0], t[31:24]};
            t = {8'(bsub(int'(t[31:24])) ^ rc), 8'(bsub(int'(t[23:16]))),
                 8'(bsub(int'(t[15:8]))), 8'(bsub(int'(t[7:0])))};
            rc = bmul(rc, 2);
         end
         w[i] = w[i-4] ^ t;
      end
      for (int r = 0; r < 11; r++) exp_k[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
   endtask

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // compare outputs against the model, then set inputs for the next edge
   task automatic tick(input logic ld, input logic [127:0] k, input logic [3:0] idx);
      logic [127:0] e;
      bit er;
      string tag;
      @(negedge clk);
      er = (since >= 10);
      tag = (since >= 11) ? "R9" : "R2";
      chk(ready == er, tag, {127'd0, ready}, {127'd0, er});
      if (rd_idx > 4'd10) chk(rd_key == '0, "R7", rd_key, '0);
      else if (since < 0) chk(rd_key == '0, "R1", rd_key, '0);
      else if (er) begin
         e = exp_k[rd_idx];
         chk(rd_key == e, (rd_idx == 0) ? "R3" : "R4", rd_key, e);
      end
      load = ld; key_in = k; rd_idx = idx;
      if (ld) begin since = 0; expand(k); end
      else if (since >= 0) since++;
   endtask

   task automatic direct(input logic [3:0] idx, input logic [127:0] e, input string req);
      tick(1'b0, '0, idx);
      #1 chk(rd_key == e, req, rd_key, e);
   endtask

   task automatic sweep();
      for (int i = 10; i >= 0; i--) tick(1'b0, '0, 4'(i));
      for (int i = 15; i >= 11; i--) tick(1'b0, '0, 4'(i));
      for (int i = 0; i < 11; i++) tick(1'b0, '0, 4'((i * 7) % 11));
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(ready == 1'b0, "R1", {127'd0, ready}, '0);
      chk(rd_key == '0, "R1", rd_key, '0);
      rst_n = 1'b1;
      tick(1'b0, '0, 4'd5);
      tick(1'b0, '0, 4'd12);
      tick(1'b0, '0, 4'd0);
      // published test key
      tick(1'b1, 128'h2b7e151628aed2a6abf7158809cf4f3c, 4'd0);
      repeat (12) tick(1'b0, '0, 4'd0);
      direct(4'd1, 128'ha0fafe1788542cb123a339392a6c7605, "R5 R6");
      direct(4'd10, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R4");
      sweep();
      // all-zero key exercises S-box of zero
      tick(1'b1, '0, 4'd3);
      repeat (11) tick(1'b0, '0, 4'd3);
      direct(4'd1, 128'h62636363626363636263636362636363, "R6");
      sweep();
      // R8: restart in mid-expansion
      tick(1'b1, 128'h00112233445566778899aabbccddeeff, 4'd2);
      repeat (4) tick(1'b0, '0, 4'd2);
      tick(1'b1, 128'hffffffffffffffffffffffffffffffff, 4'd0);
      repeat (11) tick(1'b0, '0, 4'd10);
      direct(4'd0, 128'hffffffffffffffffffffffffffffffff, "R8");
      sweep();
      // R9: long hold with shifting index
      for (int i = 0; i < 30; i++) tick(1'b0, '0, 4'(i % 16));
      // R8: back-to-back loads
      tick(1'b1, 128'h0f0e0d0c0b0a09080706050403020100, 4'd0);
      tick(1'b1, 128'h000102030405060708090a0b0c0d0e0f, 4'd0);
      tick(1'b1, 128'hdeadbeef0123456789abcdef55aa55aa, 4'd0);
      repeat (12) tick(1'b0, '0, 4'd7);
      sweep();
      tick(1'b0, '0, 4'd0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule